// File: doc/BRIEF.md
# Table-Coded Clock Divider with Stop Gate

This block makes a peripheral clock from a faster input clock. A 4-bit code picks the division ratio from a fixed lookup table. The table is sparse and not ordered: some codes are unused, and the ratios include odd and non-power-of-two values. A parameter selects one of three tables at build time: a signal-processor table, a storage-host table, or a storage-card table. The storage-card table has an optional trimmed variant. The block drives a divided clock level and a one-cycle enable strobe. The strobe marks the first input cycle of every output period. Logic that runs on the input clock can use the strobe as a clock enable.

Software sees one control word. The code sits in bits 3:0. Bit 8 is a stop gate: writing 1 stops the output and writing 0 lets it run. Bit 15 is a read-only sticky flag that records a write of an unlisted code. A new code or gate value never cuts an output period short. It is taken up when the current period ends, or at once when the output is already stopped. While stopped, both outputs stay low.

Top module: `tabdiv_clkgen`

## Requirements
- R1: After reset, bit 8 of `rdata` (the gate) is 1 and the error flag is 0. The code field holds the lowest legal code of the selected table: 1 for the signal-processor table, 0 for the storage-host table, 4 for the storage-card table, and 5 for the trimmed storage-card table. `clk_out` and `clk_en` are 0.
- R2: Each table maps codes to ratios. Signal-processor table (TABLE_SEL=0): 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48. Every other code is illegal. While running, `clk_en` pulses once every N input cycles, where N is the ratio of the code.
- R3: In each running period of N cycles, `clk_out` is high for the first floor(N/2) cycles and low for the rest. `clk_en` is high only in the first cycle of the period, and that cycle is always one where `clk_out` is high.
- R4: A write whose bits 3:0 hold an illegal code leaves the code field unchanged and sets the error flag (`rdata` bit 15, `err_flag`). The flag stays set until reset. The gate bit of the same write is still applied.
- R5: A code written while running takes effect only when the current output period ends. `clk_out` never rises except at the first cycle of a period.
- R6: A gate value written while running takes effect at the next period end. From then on both outputs stay low. After the gate is cleared on a stopped divider, a new period starts on the second clock edge after the write.
- R7: `rdata` shows the code in bits 3:0, the gate in bit 8 and the error flag in bit 15. A write updates them on the next clock edge.
- R8: In the trimmed storage-card variant (TABLE_SEL=2, DROP_FIRST=1), code 4 is illegal.
- R9: The storage-host table (TABLE_SEL=1) is the signal-processor table plus 0→2. The storage-card table (TABLE_SEL=2) has 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48 and 12→10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Writes `wdata` to the control word |
| wdata | input | REG_W | Write data: code in bits 3:0, gate in bit 8 |
| rdata | output | REG_W | Control word readback, error flag in bit 15 |
| clk_out | output | 1 | Divided clock level |
| clk_en | output | 1 | One-cycle strobe at the start of each output period |
| err_flag | output | 1 | Sticky illegal-code flag |

## Verification
A wrong period counter or a wrong latched ratio shows up within one output period. The enable strobe appears at the wrong spacing, or `clk_out` switches at the wrong cycle. A bad ratio lookup is caught the first time the code is used, because every code of every table is written with the gate open. A ratio or gate that is picked up mid-period shows as a shortened high or low phase on the cycle after the write. An illegal code that gets through shows on `rdata` at the next edge.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
  localparam int CODE_W  = 4;
  localparam int RATIO_W = 6;
  localparam int SEL_DSP  = 0;
  localparam int SEL_HOST = 1;
  localparam int SEL_CARD = 2;

  // Returns 0 for a code that the selected table does not list.
  function automatic logic [RATIO_W-1:0] code_ratio(input int sel, input bit drop,
                                                    input logic [CODE_W-1:0] c);
    logic [RATIO_W-1:0] r;
    logic               wide;
    wide = (sel == SEL_DSP) || (sel == SEL_HOST);
    r = '0;
    case (c)
      4'd0:  r = (sel == SEL_HOST) ? RATIO_W'(2) : '0;
      4'd1:  r = wide ? RATIO_W'(3) : '0;
      4'd2:  r = wide ? RATIO_W'(4) : '0;
      4'd3:  r = wide ? RATIO_W'(6) : '0;
      4'd4:  r = (wide || !drop) ? RATIO_W'(8) : '0;
      4'd5:  r = RATIO_W'(12);
      4'd6:  r = RATIO_W'(16);
      4'd7:  r = RATIO_W'(18);
      4'd8:  r = RATIO_W'(24);
      4'd10: r = RATIO_W'(36);
      4'd11: r = RATIO_W'(48);
      4'd12: r = (sel == SEL_CARD) ? RATIO_W'(10) : '0;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [CODE_W-1:0] first_code(input int sel, input bit drop);
    logic [CODE_W-1:0] f;
    f = '0;
    for (int i = (1 << CODE_W) - 1; i >= 0; i--)
      if (code_ratio(sel, drop, CODE_W'(i)) != '0) f = CODE_W'(i);
    return f;
  endfunction
endpackage

// File: rtl/tdiv_lut.sv
module tdiv_lut
  import tdiv_pkg::*;
#(
  parameter int TABLE_SEL  = 0,
  parameter bit DROP_FIRST = 1'b0
) (
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] ratio,
  output logic               legal
);
  generate
    if (TABLE_SEL == SEL_CARD) begin : g_card
      always_comb ratio = code_ratio(SEL_CARD, DROP_FIRST, code);
    end else if (TABLE_SEL == SEL_HOST) begin : g_host
      always_comb ratio = code_ratio(SEL_HOST, 1'b0, code);
    end else begin : g_dsp
      always_comb ratio = code_ratio(SEL_DSP, 1'b0, code);
    end
  endgenerate
  assign legal = (ratio != '0);
endmodule

// File: rtl/tdiv_regs.sv
module tdiv_regs
  import tdiv_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_CODE = '0,
  parameter int GATE_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_gate,
  input  logic              wr_legal,
  output logic [CODE_W-1:0] code_q,
  output logic              gate_q,
  output logic              err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= RST_CODE;
      gate_q <= 1'b1;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      gate_q <= wr_gate;
      if (wr_legal) code_q <= wr_code;
      else          err_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/tdiv_core.sv
module tdiv_core
  import tdiv_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               clk_out,
  output logic               clk_en
);
  logic               run_q, run_d;
  logic [RATIO_W-1:0] cnt_q, cnt_d, n_q, n_d;
  logic               boundary;

  assign boundary = !run_q || (cnt_q == n_q - RATIO_W'(1));

  always_comb begin
    if (boundary) begin
      run_d = !stop;
      n_d   = ratio_in;
      cnt_d = '0;
    end else begin
      run_d = run_q;
      n_d   = n_q;
      cnt_d = cnt_q + RATIO_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      n_q     <= RST_RATIO;
      clk_out <= 1'b0;
      clk_en  <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      n_q     <= n_d;
      clk_out <= run_d && (cnt_d < (n_d >> 1));
      clk_en  <= run_d && (cnt_d == '0);
    end
  end
endmodule

// File: rtl/tabdiv_clkgen.sv
module tabdiv_clkgen
  import tdiv_pkg::*;
#(
  parameter int TABLE_SEL  = 0,
  parameter bit DROP_FIRST = 1'b0,
  parameter int REG_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             clk_out,
  output logic             clk_en,
  output logic             err_flag
);
  localparam int GATE_BIT = 8;
  localparam int ERR_BIT  = 15;
  localparam logic [CODE_W-1:0]  RST_CODE  = first_code(TABLE_SEL, DROP_FIRST);
  localparam logic [RATIO_W-1:0] RST_RATIO = code_ratio(TABLE_SEL, DROP_FIRST, RST_CODE);

  logic [CODE_W-1:0]  code_q;
  logic               gate_q, err_q, wr_legal;
  logic [RATIO_W-1:0] wr_ratio, cur_ratio;
  logic               cur_legal;

  tdiv_lut #(.TABLE_SEL(TABLE_SEL), .DROP_FIRST(DROP_FIRST)) u_wr_lut (
    .code(wdata[CODE_W-1:0]), .ratio(wr_ratio), .legal(wr_legal));

  tdiv_lut #(.TABLE_SEL(TABLE_SEL), .DROP_FIRST(DROP_FIRST)) u_cur_lut (
    .code(code_q), .ratio(cur_ratio), .legal(cur_legal));

  tdiv_regs #(.RST_CODE(RST_CODE), .GATE_BIT(GATE_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wdata[CODE_W-1:0]),
    .wr_gate(wdata[GATE_BIT]), .wr_legal(wr_legal),
    .code_q(code_q), .gate_q(gate_q), .err_q(err_q));

  tdiv_core #(.RST_RATIO(RST_RATIO)) u_core (
    .clk(clk), .rst(rst), .stop(gate_q || !cur_legal), .ratio_in(cur_ratio),
    .clk_out(clk_out), .clk_en(clk_en));

  always_comb begin
    rdata = '0;
    rdata[CODE_W-1:0] = code_q;
    rdata[GATE_BIT]   = gate_q;
    rdata[ERR_BIT]    = err_q;
  end
  assign err_flag = err_q;
endmodule

// File: rtl/tdiv_chk.sv
module tdiv_chk
  import tdiv_pkg::*;
#(
  parameter int TABLE_SEL  = 0,
  parameter bit DROP_FIRST = 1'b0,
  parameter int REG_W      = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] rdata,
  input logic             clk_out,
  input logic             clk_en,
  input logic             err_flag
);
  AST_RESET_STOPPED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!clk_out && !clk_en && rdata[8] && !err_flag)); // R1
  AST_EN_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> clk_out); // R3
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out) |-> clk_en); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R4
  AST_BAD_CODE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && code_ratio(TABLE_SEL, DROP_FIRST, wdata[3:0]) == '0)
      |=> (rdata[3:0] == $past(rdata[3:0]) && err_flag)); // R4
  AST_GATE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rdata[8] == $past(wdata[8]))); // R7
endmodule

bind tabdiv_clkgen tdiv_chk #(.TABLE_SEL(TABLE_SEL), .DROP_FIRST(DROP_FIRST), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .clk_out(clk_out), .clk_en(clk_en), .err_flag(err_flag));

// File: tb/tabdiv_clkgen_tb_top.sv
module tabdiv_clkgen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rd   [4];
  logic        co   [4];
  logic        ce   [4];
  logic        ef   [4];
  int checks = 0, errors = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  tabdiv_clkgen #(.TABLE_SEL(0), .DROP_FIRST(1'b0)) dut_i (.clk(clk), .rst(rst), .wr_en(wr_en),
    .wdata(wdata), .rdata(rd[0]), .clk_out(co[0]), .clk_en(ce[0]), .err_flag(ef[0]));
  tabdiv_clkgen #(.TABLE_SEL(1), .DROP_FIRST(1'b0)) dut_host (.clk(clk), .rst(rst), .wr_en(wr_en),
    .wdata(wdata), .rdata(rd[1]), .clk_out(co[1]), .clk_en(ce[1]), .err_flag(ef[1]));
  tabdiv_clkgen #(.TABLE_SEL(2), .DROP_FIRST(1'b0)) dut_card (.clk(clk), .rst(rst), .wr_en(wr_en),
    .wdata(wdata), .rdata(rd[2]), .clk_out(co[2]), .clk_en(ce[2]), .err_flag(ef[2]));
  tabdiv_clkgen #(.TABLE_SEL(2), .DROP_FIRST(1'b1)) dut_skip (.clk(clk), .rst(rst), .wr_en(wr_en),
    .wdata(wdata), .rdata(rd[3]), .clk_out(co[3]), .clk_en(ce[3]), .err_flag(ef[3]));

  // Reference ratio per variant (0 dsp, 1 host, 2 card, 3 trimmed card); 0 = illegal.
  function automatic int ref_ratio(int v, int c);
    int dsp_tab [16] = '{0, 3, 4, 6, 8, 12, 16, 18, 24, 0, 36, 48, 0, 0, 0, 0};
    if (v == 1 && c == 0) return 2;
    if (v >= 2) begin
      if (c == 12) return 10;
      if (c < 4 || (v == 3 && c == 4)) return 0;
    end
    return dsp_tab[c];
  endfunction

  int m_code[4], m_gate[4], m_err[4], m_run[4], m_cnt[4], m_n[4];
  int def_code[4] = '{1, 0, 4, 5};

  always @(posedge clk) begin
    for (int v = 0; v < 4; v++) begin
      if (rst) begin
        m_code[v] = def_code[v]; m_gate[v] = 1; m_err[v] = 0;
        m_run[v] = 0; m_cnt[v] = 0; m_n[v] = ref_ratio(v, def_code[v]);
      end else begin
        if (m_run[v] == 0 || m_cnt[v] == m_n[v] - 1) begin
          m_run[v] = (m_gate[v] == 0) ? 1 : 0;
          m_n[v] = ref_ratio(v, m_code[v]);
          m_cnt[v] = 0;
        end else m_cnt[v] = m_cnt[v] + 1;
        if (wr_en) begin
          m_gate[v] = wdata[8];
          if (ref_ratio(v, int'(wdata[3:0])) != 0) m_code[v] = int'(wdata[3:0]);
          else m_err[v] = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Compare every instance against the model on each falling edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      for (int v = 0; v < 4; v++) begin
        int eo, ee, er;
        eo = (m_run[v] != 0 && m_cnt[v] < m_n[v] / 2) ? 1 : 0;
        ee = (m_run[v] != 0 && m_cnt[v] == 0) ? 1 : 0;
        er = (m_err[v] << 15) | (m_gate[v] << 8) | m_code[v];
        chk(co[v] == eo[0], {phase, " clk_out (R3)"}, co[v], eo);
        chk(ce[v] == ee[0], {phase, " clk_en (R2)"}, ce[v], ee);
        chk(rd[v] == er[15:0], {phase, " rdata (R7)"}, rd[v], er);
        chk(ef[v] == m_err[v][0], {phase, " err_flag (R4)"}, ef[v], m_err[v]);
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input bit gate, input int code);
    @(negedge clk); wr_en = 1'b1; wdata = 16'(code) | (16'(gate) << 8);
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_en(input int v, input int win, input int exp, input string req);
    int n;
    n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (ce[v]) n++;
    end
    chk(n == exp, req, n, exp);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    #1;
    chk(rd[0] == 16'h0101, "R1 reset word dsp", rd[0], 16'h0101);
    chk(rd[3] == 16'h0105, "R1 reset word trimmed card", rd[3], 16'h0105);
    chk(co[0] == 1'b0 && ce[0] == 1'b0, "R1 outputs low", co[0], 0);
    idle(10);
    chk(ce[1] == 1'b0, "R1 stays gated", ce[1], 0);

    phase = "R2";
    for (int c = 0; c < 16; c++) begin
      wr(1'b0, c);
      idle(110);
    end

    phase = "R9";
    wr(1'b0, 0); idle(20);
    count_en(1, 20, 10, "R9 host code0 ratio 2");
    wr(1'b0, 12); idle(30);
    count_en(2, 40, 4, "R9 card code12 ratio 10");
    wr(1'b0, 1); idle(30);
    count_en(0, 30, 10, "R2 dsp code1 ratio 3");

    phase = "R5";
    wr(1'b0, 11); idle(60);
    wr(1'b0, 3); idle(5); wr(1'b0, 5); idle(70);
    wr(1'b0, 7); wr(1'b0, 10); idle(90);

    phase = "R6";
    idle(7); wr(1'b1, 8); idle(60);
    chk(ce[0] == 1'b0 && co[0] == 1'b0, "R6 gated low", co[0], 0);
    wr(1'b0, 8); idle(50);
    wr(1'b1, 2); wr(1'b0, 2); idle(30);

    phase = "R4";
    wr(1'b0, 9);
    chk(rd[0][15] == 1'b1 && rd[0][3:0] == 4'd2, "R4 dsp code9 rejected", rd[0], 16'h8002);
    wr(1'b1, 15); idle(40);
    chk(rd[1][8] == 1'b1, "R4 gate applied on bad code", rd[1][8], 1);
    wr(1'b0, 6); idle(40);

    phase = "R8";
    wr(1'b0, 4);
    chk(rd[3][3:0] != 4'd4 && ef[3] == 1'b1, "R8 trimmed card code4 illegal", rd[3], 16'h8006);
    chk(rd[2][3:0] == 4'd4, "R8 full card accepts code4", rd[2][3:0], 4);
    idle(60);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule